// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes a single load or store instruction from a 32-lane warp. The instruction carries one byte address per lane, one access size for all lanes and an active-lane mask. The block groups the active lanes by the aligned 128-byte segment each address falls in. It issues one memory transaction per distinct segment on a valid/ready request interface, at most one transaction per clock.

Each transaction carries:
- the segment base address,
- a 128-bit byte-enable mask over that segment,
- a 32-bit map of the lanes it serves.

Inactive lanes produce no traffic. Once the last transaction of an instruction has been handed off, the block pulses a completion flag.

The block sits between an instruction issue stage and the memory request path. It admits a new instruction only when no transaction of the previous one is still outstanding. Every lane address is assumed to be naturally aligned to the access size, so no single lane's access crosses a segment boundary.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `req_valid` is 0, `instr_done` is 0 and `instr_ready` is 1.
- R2: An instruction is taken on a clock edge where `instr_valid` and `instr_ready` are both 1. `instr_ready` is 1 exactly when no transaction of an earlier instruction is pending. An `instr_valid` raised while `instr_ready` is 0 is ignored and does not change any transaction.
- R3: When 32 active lanes read consecutive 4-byte words starting at a 128-byte-aligned address, exactly one transaction is issued. In that transaction `req_lanes` is all ones, `req_bytes` is all ones and `req_base` equals that start address.
- R4: Each transaction is led by the lowest-numbered lane still pending. It serves every pending lane whose address bits [31:7] equal the leader's. Transactions therefore appear in the order of the lowest lane of each segment.
- R5: The number of transactions for an instruction equals the number of distinct 128-byte segments among its active lanes, from 1 up to 32.
- R6: A lane whose `instr_mask` bit is 0 never appears in `req_lanes`, sets no bit in `req_bytes` and causes no transaction.
- R7: The access size code in `instr_size` selects the width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. For each served lane, bits [off +: width] of `req_bytes` are set, where off is the lane address bits [6:0]. `req_base` has bits [6:0] equal to 0.
- R8: While `req_valid` is 1 and `req_ready` is 0, the next cycle keeps `req_valid` at 1 and keeps `req_base`, `req_bytes`, `req_lanes` and `req_is_store` unchanged.
- R9: `instr_done` is 1 for exactly the one cycle that follows the edge on which the last transaction of an instruction is accepted, and `req_valid` is 0 in that cycle.
- R10: An instruction with an all-zero mask issues no transaction. `instr_done` is 1 in the cycle after it is taken, and `instr_ready` is 1 again in that cycle.
- R11: `req_is_store` equals the `instr_is_store` value of the instruction on every one of its transactions.
- R12: Lanes that share one address are served by a single transaction. All of them appear in `req_lanes`, and `req_bytes` holds the union of their byte ranges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Block can take an instruction |
| instr_is_store | input | 1 | 1 for store, 0 for load |
| instr_size | input | 2 | Access size code, 0..3 selecting 1, 2, 4 or 8 bytes |
| instr_mask | input | 32 | Active lane mask, bit i for lane i |
| instr_addr | input | 1024 | Lane byte addresses, lane i at bits [32*i +: 32] |
| req_valid | output | 1 | Transaction offered |
| req_ready | input | 1 | Memory side takes the transaction |
| req_is_store | output | 1 | Operation kind of the transaction |
| req_base | output | 32 | 128-byte-aligned segment address |
| req_bytes | output | 128 | Byte enables within the segment |
| req_lanes | output | 32 | Lanes served by the transaction |
| instr_done | output | 1 | One-cycle pulse when the instruction is fully split |

## Verification
The address patterns are chosen so that a wrong grouping gives a different transaction count:
- one fully coalesced block,
- a 128-byte stride that forces 32 transactions,
- a half mask whose inactive lanes point at foreign segments,
- interleaved segments whose lowest lanes are out of address order,
- a single broadcast address.

The 1-, 2- and 8-byte sizes are each tried, and the 8-byte case spans two segments, so the byte-enable width and offset are checked apart from the grouping. An empty mask checks that completion is flagged without a transaction. One run stalls `req_ready` two cycles out of three while a second instruction is held on the input. That run separates correct holding of the request from silently dropping the stalled transaction or accepting the extra instruction.

// File: rtl/wc_pkg.sv
// Package: shared types and helpers for the warp coalescer.
// Assumes access sizes are powers of two from 1 to 8 bytes.
package wc_pkg;

    // Access width code carried with each instruction
    typedef enum logic [1:0] {
        SZ_1B = 2'd0,
        SZ_2B = 2'd1,
        SZ_4B = 2'd2,
        SZ_8B = 2'd3
    } acc_size_e;

    // Number of bytes touched by one lane for a given size code
    function automatic int unsigned access_bytes(acc_size_e sz);
        return 32'd1 << sz;
    endfunction

endpackage

// File: rtl/wc_leader.sv
// Module: wc_leader
// Finds the lowest-numbered lane whose pending bit is set.
// Assumes the caller ignores the index when no lane is pending (index is 0 then).
module wc_leader #(
    parameter int LANES = 32,
    localparam int LIDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0]  pending,
    output logic [LIDX_W-1:0] leader_idx
);

    // Priority scan from the top down so the lowest set lane wins
    always_comb begin
        leader_idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i]) begin
                leader_idx = LIDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/wc_segment_group.sv
// Module: wc_segment_group
// Given the leader lane, selects every pending lane in the same aligned
// segment and builds the segment base and the byte-enable mask.
// Assumes each lane address is naturally aligned to the access size, so a
// single lane never spans two segments.
module wc_segment_group
    import wc_pkg::*;
#(
    parameter int LANES     = 32,
    parameter int ADDR_W    = 32,
    parameter int SEG_BYTES = 128,
    localparam int OFF_W    = $clog2(SEG_BYTES),
    localparam int LIDX_W   = $clog2(LANES)
) (
    input  logic [LANES*ADDR_W-1:0] lane_addr_flat,
    input  logic [LANES-1:0]        pending,
    input  logic [LIDX_W-1:0]       leader_idx,
    input  acc_size_e               acc_size,
    output logic [LANES-1:0]        grp_lanes,
    output logic [ADDR_W-1:0]       grp_base,
    output logic [SEG_BYTES-1:0]    grp_bytes
);

    logic [ADDR_W-1:0]    lead_addr;
    logic [SEG_BYTES-1:0] span;
    logic [SEG_BYTES-1:0] lane_bytes [LANES];

    // Address of the leader lane selects the segment to serve
    always_comb begin
        lead_addr = lane_addr_flat[int'(leader_idx)*ADDR_W +: ADDR_W];
    end

    // Contiguous run of enable bits for one lane, before offsetting
    always_comb begin
        span = '0;
        for (int b = 0; b < 8; b++) begin
            if (32'(b) < access_bytes(acc_size)) begin
                span[b] = 1'b1;
            end
        end
    end

    // Per-lane segment compare and byte placement
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [ADDR_W-1:0] a;
        assign a = lane_addr_flat[g*ADDR_W +: ADDR_W];
        assign grp_lanes[g] = pending[g] &&
                              (a[ADDR_W-1:OFF_W] == lead_addr[ADDR_W-1:OFF_W]);
        assign lane_bytes[g] = grp_lanes[g] ? (span << a[OFF_W-1:0]) : '0;
    end

    // Merge the byte ranges of all selected lanes
    always_comb begin
        grp_bytes = '0;
        for (int i = 0; i < LANES; i++) begin
            grp_bytes = grp_bytes | lane_bytes[i];
        end
    end

    // Base address of the served segment
    always_comb begin
        grp_base = {lead_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end

endmodule

// File: rtl/warp_coalescer.sv
// Module: warp_coalescer
// Splits one warp memory instruction into one request per distinct aligned
// segment touched by its active lanes, one request per clock, under
// valid/ready backpressure. Pulses instr_done once all lanes are served.
// Assumes lane addresses are aligned to the access size.
module warp_coalescer
    import wc_pkg::*;
#(
    parameter int LANES     = 32,
    parameter int ADDR_W    = 32,
    parameter int SEG_BYTES = 128,
    localparam int OFF_W    = $clog2(SEG_BYTES),
    localparam int LIDX_W   = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    instr_valid,
    output logic                    instr_ready,
    input  logic                    instr_is_store,
    input  logic [1:0]              instr_size,
    input  logic [LANES-1:0]        instr_mask,
    input  logic [LANES*ADDR_W-1:0] instr_addr,
    output logic                    req_valid,
    input  logic                    req_ready,
    output logic                    req_is_store,
    output logic [ADDR_W-1:0]       req_base,
    output logic [SEG_BYTES-1:0]    req_bytes,
    output logic [LANES-1:0]        req_lanes,
    output logic                    instr_done
);

    logic [LANES-1:0]        pending_q;
    logic [LANES*ADDR_W-1:0] addr_q;
    acc_size_e               size_q;
    logic                    store_q;
    logic                    done_q;

    logic [LIDX_W-1:0]       leader_idx;
    logic [LANES-1:0]        grp_lanes;
    logic [LANES-1:0]        pending_after;
    logic                    accept;
    logic                    fire;

    wc_leader #(
        .LANES(LANES)
    ) u_leader (
        .pending    (pending_q),
        .leader_idx (leader_idx)
    );

    wc_segment_group #(
        .LANES     (LANES),
        .ADDR_W    (ADDR_W),
        .SEG_BYTES (SEG_BYTES)
    ) u_group (
        .lane_addr_flat (addr_q),
        .pending        (pending_q),
        .leader_idx     (leader_idx),
        .acc_size       (size_q),
        .grp_lanes      (grp_lanes),
        .grp_base       (req_base),
        .grp_bytes      (req_bytes)
    );

    // Handshake terms and the pending set left after the current request
    always_comb begin
        req_valid     = |pending_q;
        instr_ready   = ~req_valid;
        accept        = instr_valid && instr_ready;
        fire          = req_valid && req_ready;
        pending_after = pending_q & ~grp_lanes;
        req_lanes     = grp_lanes;
        req_is_store  = store_q;
        instr_done    = done_q;
    end

    // Instruction capture, lane retirement and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= '0;
            addr_q    <= '0;
            size_q    <= SZ_1B;
            store_q   <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= (accept && (instr_mask == '0)) ||
                      (fire && (pending_after == '0));
            if (accept) begin
                pending_q <= instr_mask;
                addr_q    <= instr_addr;
                size_q    <= acc_size_e'(instr_size);
                store_q   <= instr_is_store;
            end else if (fire) begin
                pending_q <= pending_after;
            end
        end
    end

    AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !instr_ready); // R2

    AST_HOLD_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_base) &&
        $stable(req_bytes) && $stable(req_lanes) && $stable(req_is_store))); // R8

    AST_LANES_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((req_lanes != '0) && ((req_lanes & ~pending_q) == '0))); // R6

    AST_LEADER_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_lanes[leader_idx] && ((pending_q & ((LANES'(1) << leader_idx) - LANES'(1))) == '0))); // R4

    AST_BYTES_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_bytes != '0)); // R7

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |-> !req_valid); // R9

    AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (instr_mask == '0)) |=> (instr_done && !req_valid)); // R10

endmodule

// File: tb/warp_coalescer_tb.sv
// Directed bench for warp_coalescer: one task per scenario, each checking
// its own transactions against a model computed from the requirements.
module warp_coalescer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LANES = 32;
    localparam int AW    = 32;
    localparam int SB    = 128;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              instr_valid;
    logic              instr_ready;
    logic              instr_is_store;
    logic [1:0]        instr_size;
    logic [LANES-1:0]  instr_mask;
    logic [LANES*AW-1:0] instr_addr;
    logic              req_valid;
    logic              req_ready;
    logic              req_is_store;
    logic [AW-1:0]     req_base;
    logic [SB-1:0]     req_bytes;
    logic [LANES-1:0]  req_lanes;
    logic              instr_done;

    int n_checks = 0;
    int n_errors = 0;
    logic [AW-1:0] la [LANES];

    always #(CLK_PERIOD/2) clk = ~clk;

    warp_coalescer u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .instr_valid    (instr_valid),
        .instr_ready    (instr_ready),
        .instr_is_store (instr_is_store),
        .instr_size     (instr_size),
        .instr_mask     (instr_mask),
        .instr_addr     (instr_addr),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_is_store   (req_is_store),
        .req_base       (req_base),
        .req_bytes      (req_bytes),
        .req_lanes      (req_lanes),
        .instr_done     (instr_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [SB-1:0] act, input logic [SB-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected transaction for a pending set, from R4 and R7
    task automatic model_tx(input logic [LANES-1:0] pend, input logic [1:0] sz,
                            output logic [LANES-1:0] lanes,
                            output logic [AW-1:0] base,
                            output logic [SB-1:0] bytes);
        int lead = -1;
        lanes = '0;
        bytes = '0;
        for (int i = 0; i < LANES; i++)
            if (pend[i] && lead < 0) lead = i;
        base = {la[lead][AW-1:7], 7'b0};
        for (int i = 0; i < LANES; i++) begin
            if (pend[i] && la[i][AW-1:7] == la[lead][AW-1:7]) begin
                lanes[i] = 1'b1;
                for (int b = 0; b < (1 << sz); b++)
                    bytes[int'(la[i][6:0]) + b] = 1'b1;
            end
        end
    endtask

    // Issue one instruction and follow all its transactions.
    // stall_mod: 0 = always ready, else ready one cycle out of stall_mod.
    // junk: hold a different instruction on the input while busy (R2).
    task automatic run_instr(input string req, input logic [LANES-1:0] mask,
                             input logic [1:0] sz, input bit store,
                             input int stall_mod, input bit junk,
                             output int ntx);
        logic [LANES-1:0] pend;
        logic [LANES-1:0] e_lanes;
        logic [AW-1:0]    e_base;
        logic [SB-1:0]    e_bytes;
        bit               rdy;
        int               cyc = 0;
        ntx = 0;
        @(negedge clk);
        for (int i = 0; i < LANES; i++) instr_addr[i*AW +: AW] = la[i];
        instr_mask     = mask;
        instr_size     = sz;
        instr_is_store = store;
        instr_valid    = 1'b1;
        check(instr_ready == 1'b1, "R2", "ready before issue", SB'(instr_ready), SB'(1));
        @(posedge clk);
        #1;
        instr_valid = junk;
        if (junk) begin
            instr_mask     = '1;
            instr_size     = 2'd0;
            instr_is_store = ~store;
            for (int i = 0; i < LANES; i++) instr_addr[i*AW +: AW] = 32'h00F0_0000 + AW'(i*256);
        end
        pend = mask;
        while (pend != '0 && cyc < 400) begin
            @(negedge clk);
            rdy = (stall_mod == 0) || ((cyc % stall_mod) == stall_mod - 1);
            model_tx(pend, sz, e_lanes, e_base, e_bytes);
            req_ready = rdy;
            if (rdy && ((pend & ~e_lanes) == '0)) instr_valid = 1'b0;
            #1;
            check(req_valid == 1'b1, req, "req_valid", SB'(req_valid), SB'(1));
            check(instr_ready == 1'b0, "R2", "ready while busy", SB'(instr_ready), SB'(0));
            check(req_lanes == e_lanes, req, "req_lanes", SB'(req_lanes), SB'(e_lanes));
            check(req_base == e_base, req, "req_base", SB'(req_base), SB'(e_base));
            check(req_bytes == e_bytes, req, "req_bytes", req_bytes, e_bytes);
            check(req_is_store == store, "R11", "req_is_store", SB'(req_is_store), SB'(store));
            if (rdy) begin
                pend = pend & ~e_lanes;
                ntx++;
            end
            cyc++;
        end
        @(negedge clk);
        req_ready   = 1'b0;
        instr_valid = 1'b0;
        #1;
        check(instr_done == 1'b1, (mask == '0) ? "R10" : "R9", "done pulse", SB'(instr_done), SB'(1));
        check(req_valid == 1'b0, "R9", "no request at done", SB'(req_valid), SB'(0));
        check(instr_ready == 1'b1, "R10", "ready at done", SB'(instr_ready), SB'(1));
        @(negedge clk);
        #1;
        check(instr_done == 1'b0, "R9", "done one cycle", SB'(instr_done), SB'(0));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(req_valid == 1'b0, "R1", "req_valid after reset", SB'(req_valid), SB'(0));
        check(instr_done == 1'b0, "R1", "done after reset", SB'(instr_done), SB'(0));
        check(instr_ready == 1'b1, "R1", "ready after reset", SB'(instr_ready), SB'(1));
    endtask

    task automatic t_coalesced();
        int n;
        for (int i = 0; i < LANES; i++) la[i] = 32'h0000_1000 + AW'(4*i);
        run_instr("R3", '1, 2'd2, 1'b0, 0, 1'b0, n);
        check(n == 1, "R3", "one transaction", SB'(n), SB'(1));
    endtask

    task automatic t_strided();
        int n;
        for (int i = 0; i < LANES; i++) la[i] = 32'h0002_0000 + AW'(128*i);
        run_instr("R5", '1, 2'd2, 1'b0, 0, 1'b0, n);
        check(n == 32, "R5", "one per lane", SB'(n), SB'(32));
    endtask

    task automatic t_inactive();
        int n;
        for (int i = 0; i < LANES; i++)
            la[i] = (i % 2 == 0) ? 32'h0000_4000 + AW'(4*i) : 32'h0008_0000 + AW'(128*i);
        run_instr("R6", 32'h5555_5555, 2'd2, 1'b0, 0, 1'b0, n);
        check(n == 1, "R6", "inactive lanes add none", SB'(n), SB'(1));
    endtask

    task automatic t_sizes();
        int n;
        for (int i = 0; i < LANES; i++) la[i] = 32'h0001_0000 + AW'(8*i);
        run_instr("R7", '1, 2'd3, 1'b0, 0, 1'b0, n);
        check(n == 2, "R7", "8-byte lanes span two segments", SB'(n), SB'(2));
        for (int i = 0; i < LANES; i++) la[i] = 32'h0000_3000 + AW'(4*i + 1);
        run_instr("R7", '1, 2'd0, 1'b1, 0, 1'b0, n);
        check(n == 1, "R7", "1-byte lanes", SB'(n), SB'(1));
        for (int i = 0; i < LANES; i++) la[i] = 32'h0000_5040 + AW'(2*i);
        run_instr("R7", '1, 2'd1, 1'b0, 0, 1'b0, n);
        check(n == 1, "R7", "2-byte lanes", SB'(n), SB'(1));
    endtask

    task automatic t_backpressure();
        int n;
        for (int i = 0; i < LANES; i++)
            la[i] = 32'h0000_6000 + AW'((i % 4) * 128 + (i / 4) * 4);
        run_instr("R8", '1, 2'd2, 1'b1, 3, 1'b1, n);
        check(n == 4, "R8", "four segments under stall", SB'(n), SB'(4));
    endtask

    task automatic t_order();
        int n;
        for (int i = 0; i < LANES; i++)
            la[i] = (i % 2 == 0) ? 32'h0000_9100 + AW'(4*(i/2)) : 32'h0000_9000 + AW'(4*(i/2));
        run_instr("R4", '1, 2'd2, 1'b0, 0, 1'b0, n);
        check(n == 2, "R4", "two interleaved segments", SB'(n), SB'(2));
    endtask

    task automatic t_broadcast();
        int n;
        for (int i = 0; i < LANES; i++) la[i] = 32'h0000_7044;
        run_instr("R12", '1, 2'd2, 1'b1, 0, 1'b0, n);
        check(n == 1, "R12", "broadcast single transaction", SB'(n), SB'(1));
    endtask

    task automatic t_empty();
        int n;
        for (int i = 0; i < LANES; i++) la[i] = AW'(128*i);
        run_instr("R10", '0, 2'd2, 1'b0, 0, 1'b0, n);
        check(n == 0, "R10", "no transaction", SB'(n), SB'(0));
    endtask

    initial begin
        rst_n = 1'b0;
        instr_valid = 1'b0;
        instr_is_store = 1'b0;
        instr_size = 2'd0;
        instr_mask = '0;
        instr_addr = '0;
        req_ready = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_coalesced();
        t_strided();
        t_inactive();
        t_sizes();
        t_backpressure();
        t_order();
        t_broadcast();
        t_empty();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule